// File: doc/BRIEF.md
# Column-Parallel Single-Slope Conversion Back End

This block is the digital half of a bank of single-slope analog-to-digital converters, with one converter per column. A single 11-bit counter in reflected-binary (Gray) form is shared by every column. It starts from zero when a conversion begins and advances once per counter clock while the analog ramp sweeps. Three phase-shifted copies of the counter clock are distributed with it. Each column watches its own comparator. On the first rising edge of that comparator during a conversion, the column captures the shared Gray word and the three phase levels.

Each column turns its capture into a 12-bit result. The Gray word is converted to binary and forms the upper eleven bits. The least significant bit is the majority vote of the three captured phase levels, which tells whether the comparator tripped in the early or the late half of the count period. A column whose comparator never rises during the sweep reports full scale. A done flag rises once the counter has passed its last value. The results are plain held registers with no handshake: they keep their values until the next conversion start, so no back-pressure applies.

Top module: `ssadc_backend`

## Requirements
- R1: While reset is asserted and after its release, `done` is 0 and every column code equals 4095.
- R2: A `start` pulse clears `done`, sets every column code to 4095 and zeroes the shared counter. The counter then advances by one on each following clock.
- R3: From one clock to the next, the shared Gray counter changes in at most one bit.
- R4: The count takes the values 0 to 2047. `done` rises on the clock edge that follows the edge at which the count reached 2047, which is 2048 edges after the start edge, and stays high until the next `start`.
- R5: On the first clock edge at which a column's comparator is seen high after having been low, the column stores the current count. That count appears in bits 11:1 of its code, in plain binary.
- R6: Bit 0 of a column code is 1 when at least two of the three phase levels captured at the trip edge (`phase_lvl[2:0]`) are high, and 0 otherwise.
- R7: Further comparator toggles after a column has tripped leave its code unchanged until the next `start`.
- R8: A column whose comparator never rises during the sweep reads 4095 when `done` is high.
- R9: While `done` is high, the codes hold their values and comparator edges have no effect.
- R10: A `start` during a running conversion abandons it and begins a new one from count 0, with all codes back at 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle conversion start |
| phase_lvl | input | 3 | Levels of the three phase-shifted clocks |
| cmp_in | input | NCOL | Comparator output per column, synchronous to `clk` |
| col_code | output | NCOL*12 | 12-bit result per column, column c at bits 12c+11:12c |
| done | output | 1 | Sweep complete, results final |

## Verification
The assertions assume that `start` is a single-cycle pulse, and that the comparator and phase inputs are already synchronous to `clk`, so a capture never sees a metastable level. The stimulus changes every input only at the falling edge. It gives each tripping column a distinct count, and drops a comparator to low before the start that should let it trip again. The properties therefore concern only counter stepping, the moment `done` is raised, and the holding of results, never the analog timing of a trip.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;
  localparam int CNT_W  = 11;
  localparam int CODE_W = CNT_W + 1;
  localparam int NPH    = 3;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [CODE_W-1:0] code_t;

  function automatic cnt_t bin2gray(input cnt_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic cnt_t gray2bin(input cnt_t g);
    cnt_t b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic half_sel(input logic [NPH-1:0] p);
    return (p[0] & p[1]) | (p[1] & p[2]) | (p[0] & p[2]);
  endfunction
endpackage

// File: rtl/ssadc_gray_counter.sv
module ssadc_gray_counter
  import ssadc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output cnt_t gray,
  output logic run,
  output logic done
);
  localparam cnt_t LAST_BIN = '1;
  localparam cnt_t LAST_GRAY = LAST_BIN ^ (LAST_BIN >> 1);

  cnt_t gray_nxt;
  always_comb gray_nxt = bin2gray(gray2bin(gray) + cnt_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gray <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      gray <= '0;
      run  <= 1'b1;
      done <= 1'b0;
    end else if (run) begin
      if (gray == LAST_GRAY) begin
        run  <= 1'b0;
        done <= 1'b1;
      end else begin
        gray <= gray_nxt;
      end
    end
  end
endmodule

// File: rtl/ssadc_column.sv
module ssadc_column
  import ssadc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           run,
  input  cnt_t           gray,
  input  logic [NPH-1:0] phase_lvl,
  input  logic           cmp,
  output code_t          code
);
  logic cmp_q, tripped, rise;

  always_comb rise = cmp & ~cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= 1'b0;
    else        cmp_q <= cmp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tripped <= 1'b0;
      code    <= '1;
    end else if (start) begin
      tripped <= 1'b0;
      code    <= '1;
    end else if (run && rise && !tripped) begin
      tripped <= 1'b1;
      code    <= {gray2bin(gray), half_sel(phase_lvl)};
    end
  end
endmodule

// File: rtl/ssadc_backend.sv
module ssadc_backend
  import ssadc_pkg::*;
#(
  parameter int NCOL = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NPH-1:0]         phase_lvl,
  input  logic [NCOL-1:0]        cmp_in,
  output logic [NCOL*CODE_W-1:0] col_code,
  output logic                   done
);
  cnt_t gray_w;
  logic run_w;

  ssadc_gray_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .gray  (gray_w),
    .run   (run_w),
    .done  (done)
  );

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    ssadc_column u_col (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .run       (run_w),
      .gray      (gray_w),
      .phase_lvl (phase_lvl),
      .cmp       (cmp_in[c]),
      .code      (col_code[c*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/ssadc_checker.sv
module ssadc_checker
  import ssadc_pkg::*;
#(
  parameter int NCOL = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   done,
  input logic [NCOL*CODE_W-1:0] col_code,
  input cnt_t                   gray,
  input logic                   run
);
  localparam cnt_t LAST_BIN = '1;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && gray == '0 && col_code == '1)); // R2

  AST_GRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start) |=> ($countones(gray ^ $past(gray)) <= 1)); // R3

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && gray2bin(gray) == LAST_BIN) |=> done); // R4

  AST_DONE_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && gray2bin(gray) != LAST_BIN) |=> !done); // R4

  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(col_code))); // R9
endmodule

bind ssadc_backend ssadc_checker #(.NCOL(NCOL)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .done     (done),
  .col_code (col_code),
  .gray     (gray_w),
  .run      (run_w)
);

// File: tb/test_ssadc_backend.sv
module test_ssadc_backend;
  localparam int NCOL = 8;
  localparam int CW = 12;
  localparam int NEVER = -1;
  localparam int LAST = 2047;

  localparam int       TRIP [NCOL] = '{0, 1, 100, 1023, 1024, 2000, 2047, NEVER};
  localparam bit [2:0] PH   [NCOL] = '{3'b000, 3'b011, 3'b101, 3'b110, 3'b001, 3'b111, 3'b100, 3'b111};

  logic clk = 0, rst_n = 0, start = 0, done;
  logic [2:0] phase_lvl = 0;
  logic [NCOL-1:0] cmp_in = 0;
  logic [NCOL*CW-1:0] col_code;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  ssadc_backend #(.NCOL(NCOL)) i_ssadc_backend (
    .clk(clk), .rst_n(rst_n), .start(start), .phase_lvl(phase_lvl),
    .cmp_in(cmp_in), .col_code(col_code), .done(done));

  function automatic logic [11:0] code_of(input int c);
    return col_code[c*CW +: CW];
  endfunction

  function automatic logic [11:0] expect_code(input int t, input bit [2:0] p);
    if (t < 0) return 12'd4095;
    return {11'(t), ((p[0] + p[1] + p[2]) >= 2)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 done in reset", done, 0);
    check("R1 code in reset", code_of(0), 4095);
    rst_n = 1;
    @(negedge clk);
    check("R1 done after reset", done, 0);
    check("R1 code after reset", code_of(5), 4095);

    // Table-driven sweep: R2 R4 R5 R6 R7 R8
    pulse_start();
    check("R2 done cleared", done, 0);
    for (int t = 0; t <= LAST; t++) begin
      phase_lvl = 3'b000;
      for (int c = 0; c < NCOL; c++)
        if (TRIP[c] == t) begin cmp_in[c] = 1; phase_lvl = PH[c]; end
      if (t == 50) cmp_in[1] = 0;
      if (t == 60) cmp_in[1] = 1;
      if (t == LAST) check("R4 done not before last count", done, 0);
      @(negedge clk);
    end
    check("R4 done after last count", done, 1);
    for (int c = 0; c < NCOL; c++)
      check($sformatf("R5 R6 R8 column %0d", c), code_of(c), expect_code(TRIP[c], PH[c]));
    check("R7 retrigger ignored", code_of(1), 3);

    // R9: comparator edges while done
    cmp_in = 0;
    repeat (2) @(negedge clk);
    cmp_in = 8'hFF;
    repeat (3) @(negedge clk);
    check("R9 done held", done, 1);
    check("R9 code held col7", code_of(7), 4095);
    check("R9 code held col2", code_of(2), expect_code(100, 3'b101));

    // R10: restart mid-conversion
    cmp_in = 0;
    @(negedge clk);
    pulse_start();
    for (int t = 0; t < 20; t++) begin
      phase_lvl = 3'b000;
      if (t == 5) begin cmp_in[0] = 1; phase_lvl = 3'b110; end
      if (t == 19) cmp_in[0] = 0;
      @(negedge clk);
    end
    check("R10 first capture", code_of(0), expect_code(5, 3'b110));
    pulse_start();
    check("R10 done low after restart", done, 0);
    check("R10 code reset by restart", code_of(0), 4095);
    for (int t = 0; t <= LAST; t++) begin
      phase_lvl = 3'b000;
      if (t == 7) begin cmp_in[0] = 1; phase_lvl = 3'b011; end
      @(negedge clk);
    end
    check("R10 done after restarted sweep", done, 1);
    check("R10 R5 capture after restart", code_of(0), 15);
    check("R8 untripped after restart", code_of(1), 4095);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule